// File: doc/BRIEF.md
# Three-Way Instruction Decode Steering

This block sits between an instruction fetch buffer and the rename stage. The fetch buffer presents up to three macro-instructions in program order, each with an identifying tag and a micro-op count worked out upstream. The block forms one decode group per cycle. The first instruction of the group takes the complex slot, which handles one to four micro-ops. Each of the two simple slots behind it handles an instruction of exactly one micro-op. For every micro-op it writes an abstract record, made of the instruction tag and the micro-op's index within that instruction, into a six-entry micro-op queue. The consumer pops that queue one record per cycle.

An instruction of more than four micro-ops is handed on its own to a microcode sequencer. The sequencer streams the records out over several cycles, up to three per cycle. While it runs, the decode slots are held off. A group or a sequencer burst is written only when the queue has room for all of its records. Otherwise the fetch buffer is stalled. A flush input empties the queue and abandons any sequence in progress.

Top module: `dec_steer`

## Requirements
- R1: After reset the queue is empty (`uq_valid` low), the sequencer is idle (`ucode_busy` low), and `fb_take` is 0 while no instruction is offered.
- R2: When three valid instructions of one micro-op each are offered and the queue has room, all three are taken in one cycle (`fb_take` = 3).
- R3: An instruction of two to four micro-ops in the first position writes that many records with indices 0 upward. Up to two one-micro-op instructions behind it are taken in the same cycle.
- R4: An instruction of more than one micro-op in position 1 or 2 is not taken in that cycle. Nothing behind it is taken either. It leads the next group.
- R5: An instruction of more than four micro-ops in position 0 is taken alone. In the following cycles `ucode_busy` is high, `fb_take` is 0, and the sequencer writes the records with indices 0..n-1, at most three per cycle.
- R6: A decode group or sequencer burst is written only if the queue's free entries, counted before this cycle's pop, cover all of its records. Otherwise nothing is written and `fb_take` is 0.
- R7: The queue holds at most six records. It delivers them in the order they were written, and a record at its head stays put while `uq_ready` is low.
- R8: In a cycle with `flush` high, `fb_take` is 0. In the next cycle the queue is empty and the sequencer is idle, and normal decode resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and aborts the sequencer |
| fb_valid | input | 3 | Valid flags of the three oldest fetch-buffer instructions, contiguous from bit 0 |
| fb_tag | input | 3*TAG_W | Tags of those instructions, position 0 in the low bits |
| fb_nuop | input | 3*CNT_W | Micro-op counts (1 or more) of those instructions |
| fb_take | output | 2 | Number of instructions consumed this cycle |
| ucode_busy | output | 1 | Microcode sequencer is streaming |
| uq_valid | output | 1 | Queue head holds a record |
| uq_ready | input | 1 | Consumer pops the head this cycle |
| uq_tag | output | TAG_W | Tag of the head record |
| uq_idx | output | CNT_W | Micro-op index of the head record |

## Verification
The bench feeds streams of one-micro-op instructions, a complex instruction followed by simple ones, and a multi-micro-op instruction placed behind a simple one. Between them these separate full three-wide issue, the pairing of complex and simple slots, and the in-order cut-off at a non-simple instruction. A seven-micro-op instruction shows the sequencer handoff and its three-record bursts. A queue filled with the consumer stopped shows the all-or-nothing room rule and the head holding still. Starting a sequence into a nearly full queue and then flushing shows that both the queue and the sequencer are cleared.

// File: rtl/dec_steer.sv
module dec_steer #(
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 5,
  parameter int QDEPTH   = 6,
  parameter int CPLX_MAX = 4,
  parameter int SEQ_RATE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [2:0]           fb_valid,
  input  logic [3*TAG_W-1:0]   fb_tag,
  input  logic [3*CNT_W-1:0]   fb_nuop,
  output logic [1:0]           fb_take,
  output logic                 ucode_busy,
  output logic                 uq_valid,
  input  logic                 uq_ready,
  output logic [TAG_W-1:0]     uq_tag,
  output logic [CNT_W-1:0]     uq_idx
);
  localparam int WMAX = CPLX_MAX + 2;
  localparam int PW   = $clog2(QDEPTH);
  localparam int QW   = $clog2(QDEPTH + 1);

  logic [TAG_W-1:0] mem_tag [QDEPTH];
  logic [CNT_W-1:0] mem_idx [QDEPTH];
  logic [PW-1:0]    head, tail;
  logic [QW-1:0]    cnt;
  logic [TAG_W-1:0] seq_tag;
  logic [CNT_W-1:0] seq_pos, seq_left;

  logic [TAG_W-1:0] w_tag  [WMAX];
  logic [CNT_W-1:0] w_idx  [WMAX];
  logic [PW-1:0]    w_addr [WMAX];

  int n0, n1, n2, free, grp, seq_n, wr_n, take;
  logic acc1, acc2, load, pop;

  assign n0   = int'(fb_nuop[0 +: CNT_W]);
  assign n1   = int'(fb_nuop[CNT_W +: CNT_W]);
  assign n2   = int'(fb_nuop[2*CNT_W +: CNT_W]);
  assign acc1 = fb_valid[1] && n1 == 1;
  assign acc2 = acc1 && fb_valid[2] && n2 == 1;
  assign free = QDEPTH - int'(cnt);
  assign grp  = n0 + int'(acc1) + int'(acc2);
  assign seq_n = (int'(seq_left) < SEQ_RATE) ? int'(seq_left) : SEQ_RATE;
  assign pop  = uq_ready && cnt != '0;

  always_comb begin
    wr_n = 0;
    take = 0;
    load = 1'b0;
    if (!flush) begin
      if (ucode_busy) begin
        if (seq_n <= free) wr_n = seq_n;
      end else if (fb_valid[0]) begin
        if (n0 > CPLX_MAX) begin
          take = 1;
          load = 1'b1;
        end else if (grp <= free) begin
          take = grp - n0 + 1;
          wr_n = grp;
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < WMAX; k++) begin
      if (ucode_busy) begin
        w_tag[k] = seq_tag;
        w_idx[k] = CNT_W'(int'(seq_pos) + k);
      end else if (k < n0) begin
        w_tag[k] = fb_tag[0 +: TAG_W];
        w_idx[k] = CNT_W'(k);
      end else if (k == n0) begin
        w_tag[k] = fb_tag[TAG_W +: TAG_W];
        w_idx[k] = '0;
      end else begin
        w_tag[k] = fb_tag[2*TAG_W +: TAG_W];
        w_idx[k] = '0;
      end
      if (int'(tail) + k >= QDEPTH) w_addr[k] = PW'(int'(tail) + k - QDEPTH);
      else                          w_addr[k] = PW'(int'(tail) + k);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < WMAX; k++)
      if (k < wr_n) begin
        mem_tag[w_addr[k]] <= w_tag[k];
        mem_idx[w_addr[k]] <= w_idx[k];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      ucode_busy <= 1'b0;
      seq_tag  <= '0;
      seq_pos  <= '0;
      seq_left <= '0;
    end else begin
      if (pop) head <= (int'(head) == QDEPTH - 1) ? '0 : head + 1'b1;
      if (int'(tail) + wr_n >= QDEPTH) tail <= PW'(int'(tail) + wr_n - QDEPTH);
      else                             tail <= PW'(int'(tail) + wr_n);
      cnt <= QW'(int'(cnt) + wr_n - int'(pop));
      if (load) begin
        ucode_busy <= 1'b1;
        seq_tag  <= fb_tag[0 +: TAG_W];
        seq_pos  <= '0;
        seq_left <= CNT_W'(n0);
      end else if (ucode_busy && wr_n > 0) begin
        seq_pos  <= CNT_W'(int'(seq_pos) + wr_n);
        seq_left <= CNT_W'(int'(seq_left) - wr_n);
        if (int'(seq_left) == wr_n) ucode_busy <= 1'b0;
      end
    end
  end

  assign fb_take  = 2'(take);
  assign uq_valid = cnt != '0;
  assign uq_tag   = mem_tag[head];
  assign uq_idx   = mem_idx[head];

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_busy |-> fb_take == 2'd0);
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!uq_valid && !ucode_busy));
  p_flush_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> fb_take == 2'd0);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= QDEPTH);
  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uq_valid && !uq_ready && !flush) |=> (uq_valid && $stable(uq_tag) && $stable(uq_idx)));
  p_take_inorder_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_take == 2'd3) |-> (fb_valid == 3'b111));
endmodule

// File: tb/sim_dec_steer.sv
module sim_dec_steer;
  localparam int CLK_PER = 10;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, uq_ready = 1'b0;
  logic [2:0] fb_valid = '0;
  logic [23:0] fb_tag = '0;
  logic [14:0] fb_nuop = '0;
  logic [1:0] fb_take;
  logic ucode_busy, uq_valid;
  logic [7:0] uq_tag;
  logic [4:0] uq_idx;

  int total = 0, bad = 0;
  int p_cnt [16];
  int p_n;
  int got_tag [64], got_idx [64], got_n;
  int take_log [64], tl_n, busy_cyc;
  bit done = 0;

  dec_steer u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .fb_valid(fb_valid),
    .fb_tag(fb_tag), .fb_nuop(fb_nuop), .fb_take(fb_take), .ucode_busy(ucode_busy),
    .uq_valid(uq_valid), .uq_ready(uq_ready), .uq_tag(uq_tag), .uq_idx(uq_idx));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_from(input int ptr);
    fb_valid = '0; fb_tag = '0; fb_nuop = '0;
    for (int j = 0; j < 3; j++)
      if (ptr + j < p_n) begin
        fb_valid[j] = 1'b1;
        fb_tag[j*8 +: 8] = 8'(8'h10 + ptr + j);
        fb_nuop[j*5 +: 5] = 5'(p_cnt[ptr + j]);
      end
  endtask

  task automatic run_stream();
    int ptr = 0, cyc = 0;
    got_n = 0; tl_n = 0; busy_cyc = 0;
    while (cyc < 200 && !(ptr == p_n && !ucode_busy && !uq_valid)) begin
      @(negedge clk);
      drive_from(ptr);
      uq_ready = 1'b1;
      #1;
      take_log[tl_n++] = int'(fb_take);
      if (ucode_busy) busy_cyc++;
      if (uq_valid) begin
        got_tag[got_n] = int'(uq_tag);
        got_idx[got_n] = int'(uq_idx);
        got_n++;
      end
      @(posedge clk);
      ptr += int'(fb_take);
      cyc++;
      #1;
    end
    @(negedge clk);
    fb_valid = '0;
    uq_ready = 1'b0;
  endtask

  task automatic chk_stream(input string req);
    int e = 0;
    for (int i = 0; i < p_n; i++) e += p_cnt[i];
    chk(got_n == e, req, "record count", got_n, e);
    e = 0;
    for (int i = 0; i < p_n; i++)
      for (int k = 0; k < p_cnt[i]; k++) begin
        if (e < got_n) begin
          chk(got_tag[e] == 8'h10 + i, req, "record tag", got_tag[e], 8'h10 + i);
          chk(got_idx[e] == k, req, "record index", got_idx[e], k);
        end
        e++;
      end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!uq_valid, "R1", "uq_valid after reset", int'(uq_valid), 0);
    chk(!ucode_busy, "R1", "busy after reset", int'(ucode_busy), 0);
    chk(fb_take == 0, "R1", "take idle", int'(fb_take), 0);
  endtask

  task automatic t_simple();
    p_n = 4; p_cnt[0] = 1; p_cnt[1] = 1; p_cnt[2] = 1; p_cnt[3] = 1;
    run_stream();
    chk(take_log[0] == 3, "R2", "three simple taken", take_log[0], 3);
    chk_stream("R7");
  endtask

  task automatic t_complex();
    p_n = 3; p_cnt[0] = 3; p_cnt[1] = 1; p_cnt[2] = 1;
    run_stream();
    chk(take_log[0] == 3, "R3", "complex plus two simple", take_log[0], 3);
    chk_stream("R3");
  endtask

  task automatic t_order();
    p_n = 4; p_cnt[0] = 1; p_cnt[1] = 2; p_cnt[2] = 1; p_cnt[3] = 1;
    run_stream();
    chk(take_log[0] == 1, "R4", "cut at multi-uop in slot 1", take_log[0], 1);
    chk(take_log[1] == 3, "R4", "it leads next group", take_log[1], 3);
    chk_stream("R4");
  endtask

  task automatic t_ucode();
    p_n = 2; p_cnt[0] = 7; p_cnt[1] = 1;
    run_stream();
    chk(take_log[0] == 1, "R5", "long inst taken alone", take_log[0], 1);
    chk(busy_cyc == 3, "R5", "sequencer cycles", busy_cyc, 3);
    chk(take_log[1] + take_log[2] + take_log[3] == 0, "R5", "decode blocked", take_log[1] + take_log[2] + take_log[3], 0);
    chk(take_log[4] == 1, "R5", "decode resumes", take_log[4], 1);
    chk_stream("R5");
  endtask

  task automatic t_room();
    int et [6] = '{8'h20, 8'h20, 8'h20, 8'h20, 8'h21, 8'h22};
    int ei [6] = '{0, 1, 2, 3, 0, 0};
    @(negedge clk);
    uq_ready = 1'b0;
    fb_valid = 3'b111;
    fb_tag = {8'h22, 8'h21, 8'h20};
    fb_nuop = {5'd1, 5'd1, 5'd4};
    #1;
    chk(fb_take == 3, "R6", "six records fit empty queue", int'(fb_take), 3);
    @(negedge clk);
    fb_valid = 3'b001; fb_tag = {16'h0, 8'h23}; fb_nuop = {10'h0, 5'd1};
    #1;
    chk(fb_take == 0, "R6", "full queue stalls", int'(fb_take), 0);
    chk(uq_tag == 8'h20 && uq_idx == 0, "R7", "head tag", int'(uq_tag), 8'h20);
    @(negedge clk);
    fb_valid = '0;
    #1;
    chk(uq_tag == 8'h20 && uq_idx == 0, "R7", "head held without ready", int'(uq_idx), 0);
    for (int i = 0; i < 6; i++) begin
      uq_ready = 1'b1;
      #1;
      chk(uq_valid && uq_tag == 8'(et[i]) && uq_idx == 5'(ei[i]), "R7", "drain order", int'(uq_tag) * 16 + int'(uq_idx), et[i] * 16 + ei[i]);
      @(negedge clk);
    end
    uq_ready = 1'b0;
    #1;
    chk(!uq_valid, "R7", "empty after six pops", int'(uq_valid), 0);
  endtask

  task automatic t_flush();
    @(negedge clk);
    uq_ready = 1'b0;
    fb_valid = 3'b011; fb_tag = {8'h0, 8'h31, 8'h30}; fb_nuop = {5'd0, 5'd2, 5'd2};
    @(negedge clk);
    fb_valid = 3'b001; fb_tag = {16'h0, 8'h31}; fb_nuop = {10'h0, 5'd2};
    @(negedge clk);
    fb_valid = 3'b001; fb_tag = {16'h0, 8'h32}; fb_nuop = {10'h0, 5'd9};
    #1;
    chk(fb_take == 1, "R5", "long inst loads sequencer", int'(fb_take), 1);
    @(negedge clk);
    fb_valid = '0;
    #1;
    chk(ucode_busy, "R6", "sequencer waits for room", int'(ucode_busy), 1);
    @(negedge clk);
    flush = 1'b1;
    fb_valid = 3'b001; fb_tag = {16'h0, 8'h33}; fb_nuop = {10'h0, 5'd1};
    #1;
    chk(fb_take == 0, "R8", "no take during flush", int'(fb_take), 0);
    @(negedge clk);
    flush = 1'b0; fb_valid = '0;
    #1;
    chk(!uq_valid, "R8", "queue empty after flush", int'(uq_valid), 0);
    chk(!ucode_busy, "R8", "sequencer idle after flush", int'(ucode_busy), 0);
    p_n = 2; p_cnt[0] = 1; p_cnt[1] = 1;
    run_stream();
    chk(take_log[0] == 2, "R8", "decode after flush", take_log[0], 2);
    chk_stream("R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_simple();
    t_complex();
    t_order();
    t_ucode();
    t_room();
    t_flush();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule